// File: doc/BRIEF.md
# Per-Bit Level/One-Shot Output Bank

This block owns a bank of general-purpose output pins and a small byte-wide register file that a host reaches through an index, a write strobe and a combinational read port. Every pin is set on its own to one of two behaviours. A level pin simply shows the bit last written to the output data register. A pulse pin turns a written 1 into one active-high pulse of fixed real-time length, after which the pin drops and its data bit clears itself.

All pulse pins share one two-bit width code that picks among four real-time lengths. A free-running prescaler divides the system clock down to a 10 µs tick, and every pulse channel counts its length in these ticks. Each pin has its own small channel state machine with two states: `CH_IDLE` (no pulse running) and `CH_PULSE` (counting ticks). The transitions are *launch* (`CH_IDLE` to `CH_PULSE` on a start request), *relaunch* (`CH_PULSE` to `CH_PULSE` on a start request, which reloads the count), *expire* (`CH_PULSE` to `CH_IDLE` when the tick count reaches the latched length, raising a one-cycle done strobe) and *abort* (`CH_PULSE` to `CH_IDLE` when the pin leaves pulse mode, with no done strobe).

Registers: output data at index 11h, pin status at 12h (read-only), mode at 13h (bit set = pulse), width code at 14h (bits 1:0).

Top module: `gpio_pulse_ctrl`

## Requirements
- R1: After reset the data, mode and width-code registers read 0, so every pin starts in level mode and drives 0.
- R2: For a bit whose mode bit is 0, the pin equals the data bit written at index 11h, from the cycle after the write.
- R3: For a bit whose mode bit is 1, writing 1 to its data bit drives the pin high from the cycle after the write; when the pulse ends the pin returns to 0 and the data bit reads 0.
- R4: The pulse length is set by the width code at index 14h bits 1:0: code 0 gives 50 ticks, 1 gives 100, 2 gives 2000 and 3 gives 10000, one tick being CLK_HZ/100000 clock cycles (10 µs).
- R5: Writing 1 to a data bit whose pulse is running restarts its full length from that write.
- R6: A change to the width code does not alter a pulse already running; it applies to pulses launched afterwards.
- R7: Clearing the mode bit of a pin during its pulse ends the pulse at once; the pin then shows the data bit and no longer clears itself.
- R8: Index 14h bits 7:2 always read 0 and writing them changes nothing.
- R9: Index 12h reads the live level of every pin; writing it has no effect on any pin or register.
- R10: Any index other than 11h, 12h, 13h, 14h reads 0 and a write to it changes nothing.
- R11: Writing 0 to the data bit of a pulse pin does not cut a running pulse short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 8 | Register index for both read and write |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_idx, combinational |
| pin_out | output | NBITS | Output pin levels |

## Verification
The hardest situations to reach are those where a host access lands in the middle of a running pulse: a second launch, a width-code change, a 0 written to the data bit, or the mode bit being cleared. The bench builds the block with a low clock-frequency parameter so a tick is two cycles, launches a pulse, waits a chosen number of cycles, issues the interfering write and then measures how many cycles the pin stays high against a window computed from the tick count and the unknown prescaler phase.

// File: rtl/gpio_pulse_pkg.sv
package gpio_pulse_pkg;

    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_PULSE = 1'b1
    } ch_state_e;

    localparam logic [7:0] IDX_DATA  = 8'h11;
    localparam logic [7:0] IDX_PIN   = 8'h12;
    localparam logic [7:0] IDX_MODE  = 8'h13;
    localparam logic [7:0] IDX_WIDTH = 8'h14;

    localparam int WCODE_W = 2;

endpackage

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen #(
    parameter int DIV = 1250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(DIV - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign tick = (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/gpio_pulse_chan.sv
module gpio_pulse_chan
    import gpio_pulse_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pulse_mode,
    input  logic             start,
    input  logic [CNT_W-1:0] limit,
    output logic             active,
    output logic             done
);
    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_q, lim_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        done    = 1'b0;
        active  = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (pulse_mode && start) begin
                    // launch: width latched here
                    state_d = CH_PULSE;
                    cnt_d   = '0;
                    lim_d   = limit;
                end
            end
            CH_PULSE: begin
                active = 1'b1;
                if (!pulse_mode) begin
                    // abort
                    state_d = CH_IDLE;
                    cnt_d   = '0;
                end else if (start) begin
                    // relaunch
                    cnt_d = '0;
                    lim_d = limit;
                end else if (tick) begin
                    if (cnt_q + 1'b1 >= lim_q) begin
                        // expire
                        state_d = CH_IDLE;
                        cnt_d   = '0;
                        done    = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end
endmodule

// File: rtl/gpio_pulse_ctrl.sv
module gpio_pulse_ctrl
    import gpio_pulse_pkg::*;
#(
    parameter int NBITS      = 8,
    parameter int CLK_HZ     = 125_000_000,
    parameter int TICK_HZ    = 100_000,
    parameter int W0_TICKS   = 50,
    parameter int W1_TICKS   = 100,
    parameter int W2_TICKS   = 2000,
    parameter int W3_TICKS   = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       reg_idx,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic [NBITS-1:0] pin_out
);
    localparam int DIV   = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
    localparam int MAXT  = W3_TICKS;
    localparam int CNT_W = $clog2(MAXT + 1);

    logic [NBITS-1:0]   data_q;
    logic [NBITS-1:0]   mode_q;
    logic [WCODE_W-1:0] wcode_q;
    logic [NBITS-1:0]   ch_active;
    logic [NBITS-1:0]   ch_done;
    logic [NBITS-1:0]   ch_start;
    logic [CNT_W-1:0]   sel_limit;
    logic               tick;
    logic               wr_data, wr_mode, wr_width;

    assign wr_data  = reg_wr && (reg_idx == IDX_DATA);
    assign wr_mode  = reg_wr && (reg_idx == IDX_MODE);
    assign wr_width = reg_wr && (reg_idx == IDX_WIDTH);

    gpio_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    always_comb begin
        unique case (wcode_q)
            2'd0: sel_limit = CNT_W'(W0_TICKS);
            2'd1: sel_limit = CNT_W'(W1_TICKS);
            2'd2: sel_limit = CNT_W'(W2_TICKS);
            default: sel_limit = CNT_W'(W3_TICKS);
        endcase
    end

    assign ch_start = {NBITS{wr_data}} & mode_q & reg_wdata[NBITS-1:0];

    genvar gi;
    generate
        for (gi = 0; gi < NBITS; gi++) begin : g_ch
            gpio_pulse_chan #(.CNT_W(CNT_W)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (tick),
                .pulse_mode(mode_q[gi]),
                .start     (ch_start[gi]),
                .limit     (sel_limit),
                .active    (ch_active[gi]),
                .done      (ch_done[gi])
            );
            assign pin_out[gi] = mode_q[gi] ? ch_active[gi] : data_q[gi];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            mode_q  <= '0;
            wcode_q <= '0;
        end else begin
            for (int b = 0; b < NBITS; b++) begin
                if (ch_start[b]) begin
                    data_q[b] <= 1'b1;
                end else if (ch_done[b]) begin
                    data_q[b] <= 1'b0;
                end else if (wr_data && !mode_q[b]) begin
                    data_q[b] <= reg_wdata[b];
                end
            end
            if (wr_mode) begin
                mode_q <= reg_wdata[NBITS-1:0];
            end
            if (wr_width) begin
                wcode_q <= reg_wdata[WCODE_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            IDX_DATA:  reg_rdata[NBITS-1:0]   = data_q;
            IDX_PIN:   reg_rdata[NBITS-1:0]   = pin_out;
            IDX_MODE:  reg_rdata[NBITS-1:0]   = mode_q;
            IDX_WIDTH: reg_rdata[WCODE_W-1:0] = wcode_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pulse_ctrl_chk.sv
module gpio_pulse_ctrl_chk #(
    parameter int NBITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       reg_idx,
    input logic             reg_wr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic [NBITS-1:0] pin_out,
    input logic [NBITS-1:0] mode_q,
    input logic [1:0]       wcode_q
);
    a_r2_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == 8'h11 && mode_q == '0) |=> (pin_out == $past(reg_wdata[NBITS-1:0])));

    a_r3_pulse_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == 8'h11) |=>
        ((pin_out & $past(reg_wdata[NBITS-1:0] & mode_q)) == $past(reg_wdata[NBITS-1:0] & mode_q)));

    a_r8_width_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 8'h14) |-> (reg_rdata[7:2] == 6'd0));

    a_r9_status_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == 8'h12) |=> ($stable(mode_q) && $stable(wcode_q)));

    a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx < 8'h11 || reg_idx > 8'h14) |-> (reg_rdata == 8'd0));
endmodule

bind gpio_pulse_ctrl gpio_pulse_ctrl_chk #(.NBITS(NBITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_idx  (reg_idx),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pin_out  (pin_out),
    .mode_q   (mode_q),
    .wcode_q  (wcode_q)
);

// File: tb/test_gpio_pulse_ctrl.sv
module test_gpio_pulse_ctrl;
    localparam int CLK_HZ = 200_000;
    localparam int DIV    = CLK_HZ / 100_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_idx = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] pin_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    gpio_pulse_ctrl #(.NBITS(8), .CLK_HZ(CLK_HZ)) i_gpio_pulse_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_idx  (reg_idx),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pin_out  (pin_out)
    );

    function automatic int ticks_of(input int code);
        case (code)
            0: return 50;
            1: return 100;
            2: return 2000;
            default: return 10000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_idx = 8'h00;
    endtask

    task automatic rd(input logic [7:0] idx, output logic [7:0] d);
        reg_idx = idx;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // cycles that bit b stays high from now
    task automatic measure(input int b, input int cap, output int len);
        len = 0;
        while (pin_out[b] && len < cap) begin
            @(negedge clk);
            len++;
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

    initial begin
        logic [7:0] r;
        int len, n;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        rd(8'h11, r); chk(r == 0, "R1 data", r, 0);
        rd(8'h13, r); chk(r == 0, "R1 mode", r, 0);
        rd(8'h14, r); chk(r == 0, "R1 width", r, 0);
        chk(pin_out == 0, "R1 pins", pin_out, 0);

        // R2 / R9 exhaustive level sweep
        for (int v = 0; v < 256; v++) begin
            wr(8'h11, 8'(v));
            chk(pin_out == 8'(v), "R2 pin", pin_out, v);
            rd(8'h11, r); chk(r == 8'(v), "R2 data", r, v);
            rd(8'h12, r); chk(r == 8'(v), "R9 status", r, v);
        end

        // R9 write to status ignored
        wr(8'h11, 8'h3C);
        wr(8'h12, 8'hA5);
        chk(pin_out == 8'h3C, "R9 write ignored", pin_out, 8'h3C);

        // R8 reserved width bits
        wr(8'h14, 8'hFF); rd(8'h14, r); chk(r == 8'h03, "R8 rd", r, 3);
        wr(8'h14, 8'hFE); rd(8'h14, r); chk(r == 8'h02, "R8 rd2", r, 2);
        wr(8'h14, 8'h00);

        // R10 undefined indices: read 0, writes no effect
        for (int i = 0; i < 256; i++) begin
            if (i < 8'h11 || i > 8'h14) begin
                wr(8'(i), 8'hFF);
                rd(8'(i), r); chk(r == 0, "R10 undef read", r, 0);
            end
        end
        rd(8'h11, r); chk(r == 8'h3C, "R10 data kept", r, 8'h3C);
        rd(8'h13, r); chk(r == 8'h00, "R10 mode kept", r, 0);
        rd(8'h14, r); chk(r == 8'h00, "R10 width kept", r, 0);
        chk(pin_out == 8'h3C, "R10 pins kept", pin_out, 8'h3C);

        // R3 / R4 each width code on bit 0
        wr(8'h11, 8'h00);
        wr(8'h13, 8'h01);
        for (int c = 0; c < 4; c++) begin
            n = ticks_of(c) * DIV;
            wr(8'h14, 8'(c));
            wr(8'h11, 8'h01);
            chk(pin_out[0] == 1'b1, "R3 launch", pin_out[0], 1);
            measure(0, n + 10, len);
            chk(len >= n - DIV + 1 && len <= n, "R4 width", len, n);
            rd(8'h11, r); chk(r[0] == 1'b0, "R3 self clear", r[0], 0);
            chk(pin_out[0] == 1'b0, "R3 pin low", pin_out[0], 0);
        end

        // R2 / R3 mixed bank: high nibble pulse, low nibble level
        wr(8'h14, 8'h00);
        wr(8'h13, 8'hF0);
        wr(8'h11, 8'hFF);
        chk(pin_out == 8'hFF, "R3 mixed launch", pin_out, 8'hFF);
        measure(7, 200, len);
        chk(pin_out == 8'h0F, "R2 mixed after", pin_out, 8'h0F);
        rd(8'h11, r); chk(r == 8'h0F, "R3 mixed data", r, 8'h0F);

        // R5 restart
        wr(8'h11, 8'h00);
        wr(8'h13, 8'h01);
        wr(8'h11, 8'h01);
        wait_cyc(60);
        wr(8'h11, 8'h01);
        n = 50 * DIV;
        measure(0, n + 10, len);
        chk(len >= n - DIV + 1 && len <= n, "R5 restart", len, n);

        // R6 width change mid pulse
        wr(8'h14, 8'h01);
        wr(8'h11, 8'h01);
        wr(8'h14, 8'h00);
        n = 100 * DIV - 1;
        measure(0, n + 10, len);
        chk(len >= n - DIV && len <= n, "R6 running kept", len, n);
        wr(8'h11, 8'h01);
        n = 50 * DIV;
        measure(0, n + 10, len);
        chk(len >= n - DIV + 1 && len <= n, "R6 next uses new", len, n);

        // R11 zero write does not cut pulse
        wr(8'h11, 8'h01);
        wr(8'h11, 8'h00);
        chk(pin_out[0] == 1'b1, "R11 still high", pin_out[0], 1);
        n = 50 * DIV - 1;
        measure(0, n + 10, len);
        chk(len >= n - DIV && len <= n, "R11 full length", len, n);

        // R7 leave pulse mode mid pulse
        wr(8'h14, 8'h01);
        wr(8'h11, 8'h01);
        wait_cyc(20);
        wr(8'h13, 8'h00);
        chk(pin_out[0] == 1'b1, "R7 follows data", pin_out[0], 1);
        wait_cyc(300);
        chk(pin_out[0] == 1'b1, "R7 no self clear", pin_out[0], 1);
        rd(8'h11, r); chk(r[0] == 1'b1, "R7 data kept", r[0], 1);
        wr(8'h11, 8'h00);
        chk(pin_out[0] == 1'b0, "R7 level low", pin_out[0], 0);

        finished = 1'b1;
        summary();
    end
endmodule